// File: doc/BRIEF.md
# Serial Flash Transaction Sequencer

This block runs one serial flash transaction at a time, under software control. Software writes a small set of word registers: the opcode bytes, the address, the option bytes, the phase enables, the lane widths, the chip-select delays and the outgoing data. It then writes the start bit. The sequencer lowers chip select, waits out the setup delay and steps through the enabled phases in a fixed order. It shifts each phase MSB first over one, two or four IO lanes. At the end it releases the bus and raises a completion flag, which software polls.

Each phase can be switched on or off on its own and has its own lane width. The byte count of a phase is given as a left-justified nibble mask. The address, option and data phases can run at double data rate. A keep bit leaves chip select low at the end of a transaction, so that the next transaction continues the same frame. Read data is captured into a 64-bit receive register, and software reads it back through two data words.

Top module: `sfseq_top`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io_oe is 0, and the status word (index 8) reads 0.
- R2: A transaction runs the enabled phases in this order: first opcode, second opcode, address, option bytes, dummy cycles, data. Disabled phases are skipped. The enable bits are in the phase word (index 4): bit 0 enables the first opcode, bit 1 the second opcode, bit 16 the dummy phase. The opcodes are in the opcode word (index 1): [7:0] first, [15:8] second.
- R3: The lane word (index 5) holds a 2-bit width code per phase: [1:0] first opcode, [3:2] second opcode, [5:4] address, [7:6] option, [9:8] data. Code 0 selects one lane, 1 selects two lanes, and 2 or 3 select four lanes. Each group of bits is taken MSB first, bit n of the group drives io_out[n], and io_oe is 0001, 0011 or 1111.
- R4: The address mask is phase word [7:4]. Mask 0xF sends all 32 bits of the address word (index 2); mask 0x7 sends bits [23:0]. Both are sent most significant bit first.
- R5: The option mask (phase word [11:8]) and the data mask ([15:12]) count bytes as set bits: 1000 is 1 byte, 1100 is 2 bytes, 1111 is 4 bytes. Option bytes leave from bit 31 of the option word (index 3) downward. Write data leaves from bit 31 of the low data word (index 6) downward. When phase word bit 22 is set with data mask 1111, 8 bytes are sent: first the high data word (index 7), then the low data word.
- R6: The dummy phase gives (phase word [21:17] + 1) sck rising edges, with io_oe at 0.
- R7: Control word (index 0) bit 1 selects a read data phase. One lane samples io_in[1], two lanes sample io_in[1:0], four lanes sample io_in[3:0]. The received bytes are right-justified in read-back word 6, and an 8-byte read places its first four bytes in word 7.
- R8: DDR flags are in lane word [20:16], one per phase in the R3 order. A phase with its flag set shifts one group on every sck edge, so 8 groups give 4 rising edges.
- R9: With control bit 3 (keep) set, cs_n stays 0 after the transaction ends and status bit 1 reads 1. The next start skips the setup delay, and its first sck rise comes 3 cycles after the start write.
- R10: A start with cs_n high lowers cs_n. The first sck rise follows setup+4 clock cycles later, where setup is field [2:0] of the timing word (index 9). Hold is field [6:4] and idle is field [10:8].
- R11: Status bit 0 clears when a start (control bit 0) is accepted. It sets once the transaction has finished and cs_n is high again (or held low under keep). While it is set, sck is 0 and io_oe is 0.
- R12: While cs_n is 1, sck stays 0 and io_oe stays 0. Control bit 2 selects a write data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word index for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register word index for reads |
| rd_data | output | 32 | Register read data (combinational) |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Outgoing lane values |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Incoming lane values |

## Verification
The hardest case to reach from the ports is a frame held open across two transactions. The first start must leave chip select low, and the second must skip the setup delay without a glitch on cs_n. The bench runs an opcode-only transaction with keep set, rewrites the phase word while the select is still low, and then starts a read. It counts every rising edge of cs_n across both transactions and measures the cycles from the start write to the first clock edge. Double-rate phases are checked through the count of rising clock edges against the groups the scoreboard expects.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SETUP, ST_LOAD, ST_SHIFT, ST_END, ST_HOLD, ST_GAP
   } seq_st_e;

   localparam logic [2:0] PH_LAST = 3'd6;

   typedef struct packed {
      logic        en;
      logic        drive;
      logic        capture;
      logic        ddr;
      logic [2:0]  lanes;
      logic [6:0]  nbits;
      logic [63:0] val;
   } phase_t;

   function automatic logic [2:0] lanes_of(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [2:0] ones4(input logic [3:0] m);
      return {2'b0, m[0]} + {2'b0, m[1]} + {2'b0, m[2]} + {2'b0, m[3]};
   endfunction

endpackage

// File: rtl/sfseq_regs.sv
module sfseq_regs #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [31:0]   wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [31:0]   rd_data,
   input  logic [63:0]   rx,
   input  logic          done,
   input  logic          cs_n,
   output logic          go,
   output logic          rd_dir,
   output logic          wr_dir,
   output logic          keep,
   output logic [15:0]   cmd_q,
   output logic [31:0]   addr_q,
   output logic [31:0]   opt_q,
   output logic [22:0]   en_q,
   output logic [9:0]    lane_q,
   output logic [4:0]    ddr_q,
   output logic [31:0]   wd0_q,
   output logic [31:0]   wd1_q,
   output logic [2:0]    t_setup,
   output logic [2:0]    t_hold,
   output logic [2:0]    t_idle
);
   localparam logic [AW-1:0] A_CTRL = AW'(0);
   localparam logic [AW-1:0] A_CMD  = AW'(1);
   localparam logic [AW-1:0] A_ADDR = AW'(2);
   localparam logic [AW-1:0] A_OPT  = AW'(3);
   localparam logic [AW-1:0] A_EN   = AW'(4);
   localparam logic [AW-1:0] A_LANE = AW'(5);
   localparam logic [AW-1:0] A_D0   = AW'(6);
   localparam logic [AW-1:0] A_D1   = AW'(7);
   localparam logic [AW-1:0] A_STAT = AW'(8);
   localparam logic [AW-1:0] A_TIM  = AW'(9);

   assign go = wr_en && (wr_addr == A_CTRL) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {keep, wr_dir, rd_dir} <= '0;
         cmd_q <= '0; addr_q <= '0; opt_q <= '0; en_q <= '0;
         lane_q <= '0; ddr_q <= '0; wd0_q <= '0; wd1_q <= '0;
         t_setup <= '0; t_hold <= '0; t_idle <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: {keep, wr_dir, rd_dir} <= wr_data[3:1];
            A_CMD:  cmd_q  <= wr_data[15:0];
            A_ADDR: addr_q <= wr_data;
            A_OPT:  opt_q  <= wr_data;
            A_EN:   en_q   <= wr_data[22:0];
            A_LANE: begin lane_q <= wr_data[9:0]; ddr_q <= wr_data[20:16]; end
            A_D0:   wd0_q  <= wr_data;
            A_D1:   wd1_q  <= wr_data;
            A_TIM:  begin t_setup <= wr_data[2:0]; t_hold <= wr_data[6:4]; t_idle <= wr_data[10:8]; end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = {28'b0, keep, wr_dir, rd_dir, 1'b0};
         A_CMD:   rd_data = {16'b0, cmd_q};
         A_ADDR:  rd_data = addr_q;
         A_OPT:   rd_data = opt_q;
         A_EN:    rd_data = {9'b0, en_q};
         A_LANE:  rd_data = {11'b0, ddr_q, 6'b0, lane_q};
         A_D0:    rd_data = rx[31:0];
         A_D1:    rd_data = rx[63:32];
         A_STAT:  rd_data = {30'b0, ~cs_n, done};
         A_TIM:   rd_data = {21'b0, t_idle, 1'b0, t_hold, 1'b0, t_setup};
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/sfseq_phase.sv
module sfseq_phase
   import sfseq_pkg::*;
(
   input  logic [2:0]  idx,
   input  logic [15:0] cmd_q,
   input  logic [31:0] addr_q,
   input  logic [31:0] opt_q,
   input  logic [22:0] en_q,
   input  logic [9:0]  lane_q,
   input  logic [4:0]  ddr_q,
   input  logic [31:0] wd0_q,
   input  logic [31:0] wd1_q,
   input  logic        rd_dir,
   input  logic        wr_dir,
   output phase_t      ph
);
   logic [2:0] n_adr, n_opt, n_dat;
   logic       dbl;

   assign n_adr = ones4(en_q[7:4]);
   assign n_opt = ones4(en_q[11:8]);
   assign n_dat = ones4(en_q[15:12]);
   assign dbl   = en_q[22] && (n_dat == 3'd4);

   always_comb begin
      ph = '0;
      case (idx)
         3'd0: begin
            ph.en = en_q[0]; ph.drive = 1'b1; ph.ddr = ddr_q[0];
            ph.lanes = lanes_of(lane_q[1:0]); ph.nbits = 7'd8;
            ph.val = {cmd_q[7:0], 56'b0};
         end
         3'd1: begin
            ph.en = en_q[1]; ph.drive = 1'b1; ph.ddr = ddr_q[1];
            ph.lanes = lanes_of(lane_q[3:2]); ph.nbits = 7'd8;
            ph.val = {cmd_q[15:8], 56'b0};
         end
         3'd2: begin
            ph.en = (n_adr != 3'd0); ph.drive = 1'b1; ph.ddr = ddr_q[2];
            ph.lanes = lanes_of(lane_q[5:4]); ph.nbits = {1'b0, n_adr, 3'b0};
            ph.val = {addr_q, 32'b0} << {3'd4 - n_adr, 3'b0};
         end
         3'd3: begin
            ph.en = (n_opt != 3'd0); ph.drive = 1'b1; ph.ddr = ddr_q[3];
            ph.lanes = lanes_of(lane_q[7:6]); ph.nbits = {1'b0, n_opt, 3'b0};
            ph.val = {opt_q, 32'b0};
         end
         3'd4: begin
            ph.en = en_q[16]; ph.lanes = 3'd1;
            ph.nbits = {2'b0, en_q[21:17]} + 7'd1;
         end
         3'd5: begin
            ph.en = (rd_dir || wr_dir) && (n_dat != 3'd0);
            ph.drive = !rd_dir; ph.capture = rd_dir; ph.ddr = ddr_q[4];
            ph.lanes = lanes_of(lane_q[9:8]);
            ph.nbits = dbl ? 7'd64 : {1'b0, n_dat, 3'b0};
            ph.val = dbl ? {wd1_q, wd0_q} : {wd0_q, 32'b0};
         end
         default: ph = '0;
      endcase
   end
endmodule

// File: rtl/sfseq_engine.sv
module sfseq_engine
   import sfseq_pkg::*;
#(
   parameter int IN1_LANE = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic        keep,
   input  phase_t      ph,
   input  logic [2:0]  t_setup,
   input  logic [2:0]  t_hold,
   input  logic [2:0]  t_idle,
   input  logic [3:0]  io_in,
   output logic [2:0]  idx,
   output logic        cs_n,
   output logic        sck,
   output logic [3:0]  io_out,
   output logic [3:0]  io_oe,
   output logic [63:0] rx,
   output logic        done,
   output logic        busy
);
   seq_st_e     st;
   logic [63:0] sh;
   logic [6:0]  left;
   logic [2:0]  lanes_q, tcnt;
   logic        ddr_q, cap_q, drv_q, half, step, in1;
   logic [3:0]  grp, oe_m, inb;

   generate
      if (IN1_LANE == 1) begin : g_in_lane1
         assign in1 = io_in[1];
      end else begin : g_in_lane0
         assign in1 = io_in[0];
      end
   endgenerate

   assign busy = (st != ST_IDLE);
   assign step = (st == ST_SHIFT) && (ddr_q || half);

   always_comb begin
      case (lanes_q)
         3'd1:    begin grp = {3'b0, sh[63]};    oe_m = 4'b0001; inb = {3'b0, in1}; end
         3'd2:    begin grp = {2'b0, sh[63:62]}; oe_m = 4'b0011; inb = {2'b0, io_in[1:0]}; end
         default: begin grp = sh[63:60];         oe_m = 4'b1111; inb = io_in; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; cs_n <= 1'b1; sck <= 1'b0; io_out <= '0; io_oe <= '0;
         sh <= '0; left <= '0; lanes_q <= 3'd1; tcnt <= '0; idx <= '0;
         ddr_q <= 1'b0; cap_q <= 1'b0; drv_q <= 1'b0; half <= 1'b0;
         rx <= '0; done <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (go) begin
               done <= 1'b0; rx <= '0; idx <= '0;
               if (cs_n) begin
                  cs_n <= 1'b0; tcnt <= t_setup; st <= ST_SETUP;
               end else begin
                  st <= ST_LOAD;
               end
            end
            ST_SETUP: if (tcnt == '0) st <= ST_LOAD; else tcnt <= tcnt - 3'd1;
            ST_LOAD: begin
               sck <= 1'b0; io_oe <= '0; io_out <= '0; half <= 1'b0;
               if (idx == PH_LAST) begin
                  st <= ST_END;
               end else if (ph.en) begin
                  sh <= ph.val; left <= ph.nbits; lanes_q <= ph.lanes;
                  ddr_q <= ph.ddr; cap_q <= ph.capture; drv_q <= ph.drive;
                  st <= ST_SHIFT;
               end else begin
                  idx <= idx + 3'd1;
               end
            end
            ST_SHIFT: begin
               if (ddr_q || !half) begin
                  io_out <= drv_q ? grp : 4'b0;
                  io_oe  <= drv_q ? oe_m : 4'b0;
               end
               if (ddr_q) sck <= ~sck;
               else begin sck <= half; half <= ~half; end
               if (step) begin
                  sh   <= sh << lanes_q;
                  if (cap_q) rx <= (rx << lanes_q) | {60'b0, inb};
                  left <= left - {4'b0, lanes_q};
                  if (left <= {4'b0, lanes_q}) begin
                     idx <= idx + 3'd1; st <= ST_LOAD;
                  end
               end
            end
            ST_END: if (keep) begin
               done <= 1'b1; st <= ST_IDLE;
            end else begin
               tcnt <= t_hold; st <= ST_HOLD;
            end
            ST_HOLD: if (tcnt == '0) begin
               cs_n <= 1'b1; tcnt <= t_idle; st <= ST_GAP;
            end else tcnt <= tcnt - 3'd1;
            ST_GAP: if (tcnt == '0) begin
               done <= 1'b1; st <= ST_IDLE;
            end else tcnt <= tcnt - 3'd1;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sfseq_top.sv
module sfseq_top
   import sfseq_pkg::*;
#(
   parameter int AW       = 4,
   parameter int IN1_LANE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [31:0]   wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [31:0]   rd_data,
   output logic          cs_n,
   output logic          sck,
   output logic [3:0]    io_out,
   output logic [3:0]    io_oe,
   input  logic [3:0]    io_in
);
   generate
      if (AW < 4) begin : g_bad_aw
         $error("sfseq_top: AW must cover ten register words");
      end
      if (IN1_LANE < 0 || IN1_LANE > 1) begin : g_bad_lane
         $error("sfseq_top: IN1_LANE must be 0 or 1");
      end
   endgenerate

   logic        go_w, busy_w, done_w, rd_dir, wr_dir, keep;
   logic [15:0] cmd_q;
   logic [31:0] addr_q, opt_q, wd0_q, wd1_q;
   logic [22:0] en_q;
   logic [9:0]  lane_q;
   logic [4:0]  ddr_q;
   logic [2:0]  t_setup, t_hold, t_idle, idx;
   logic [63:0] rx;
   phase_t      ph;

   sfseq_regs #(.AW(AW)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .rx(rx), .done(done_w), .cs_n(cs_n),
      .go(go_w), .rd_dir(rd_dir), .wr_dir(wr_dir), .keep(keep),
      .cmd_q(cmd_q), .addr_q(addr_q), .opt_q(opt_q), .en_q(en_q), .lane_q(lane_q),
      .ddr_q(ddr_q), .wd0_q(wd0_q), .wd1_q(wd1_q),
      .t_setup(t_setup), .t_hold(t_hold), .t_idle(t_idle)
   );

   sfseq_phase i_phase (
      .idx(idx), .cmd_q(cmd_q), .addr_q(addr_q), .opt_q(opt_q), .en_q(en_q),
      .lane_q(lane_q), .ddr_q(ddr_q), .wd0_q(wd0_q), .wd1_q(wd1_q),
      .rd_dir(rd_dir), .wr_dir(wr_dir), .ph(ph)
   );

   sfseq_engine #(.IN1_LANE(IN1_LANE)) i_engine (
      .clk(clk), .rst_n(rst_n), .go(go_w), .keep(keep), .ph(ph),
      .t_setup(t_setup), .t_hold(t_hold), .t_idle(t_idle), .io_in(io_in),
      .idx(idx), .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe),
      .rx(rx), .done(done_w), .busy(busy_w)
   );
endmodule

// File: rtl/sfseq_chk.sv
module sfseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       go,
   input logic       busy,
   input logic       done,
   input logic       cs_n,
   input logic       sck,
   input logic [3:0] io_oe
);
   // R12: bus is quiet while deselected
   a_r12_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);
   a_r12_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (io_oe == 4'b0000));
   // R3: only the three legal lane patterns are ever enabled
   a_r3_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));
   // R11: accepted start clears the completion flag
   a_r11_go_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> !done);
   // R11: completion means clock low and lanes released
   a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!sck && io_oe == 4'b0000));
   // R10: chip select only falls in response to a start
   a_r10_cs_fall_on_go: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(go));
endmodule

bind sfseq_top sfseq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .go(go_w), .busy(busy_w), .done(done_w),
   .cs_n(cs_n), .sck(sck), .io_oe(io_oe)
);

// File: tb/test_sfseq_top.sv
module test_sfseq_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        cs_n, sck;
   logic [3:0]  io_out, io_oe;
   logic [3:0]  io_in = '0;

   int total = 0;
   int bad = 0;
   int rises = 0;
   int cs_rises = 0;
   logic prev_sck = 1'b0;
   logic prev_cs = 1'b1;
   logic [7:0] q[$];

   sfseq_top i_sfseq_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cs_n(cs_n), .sck(sck),
      .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: one entry per rising sck while lanes are driven
   always @(negedge clk) begin
      if (rst_n) begin
         if (sck && !prev_sck && !cs_n) begin
            rises++;
            if (io_oe != 4'b0000) begin
               if (q.size() == 0) chk("R2 unexpected group", {56'b0, io_oe, io_out}, 64'hDEAD);
               else begin
                  logic [7:0] e;
                  e = q.pop_front();
                  chk("R3 lane group", {56'b0, io_oe, io_out}, {56'b0, e});
               end
            end
         end
         if (cs_n && !prev_cs) cs_rises++;
      end
      prev_sck = sck;
      prev_cs  = cs_n;
   end

   task automatic push_phase(input logic [63:0] v, input int nbits, input int l, input bit ddr);
      for (int k = 0; k < nbits / l; k++) begin
         logic [63:0] t;
         logic [3:0]  g, m;
         t = v >> (64 - l * (k + 1));
         m = 4'((1 << l) - 1);
         g = t[3:0] & m;
         if (!ddr || (k % 2) == 0) q.push_back({m, g});
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_done;
      logic [31:0] s;
      int n;
      n = 0;
      rd(4'd8, s);
      while (!s[0] && n < 5000) begin
         @(negedge clk);
         rd(4'd8, s);
         n++;
      end
      if (!s[0]) chk("R11 completion timeout", 64'(s), 64'h1);
   endtask

   // start, measure cycles to the first sck rise, then wait for completion
   task automatic launch(input logic [31:0] ctrl, output int lat);
      logic [31:0] s;
      rises = 0;
      wr(4'd0, ctrl | 32'h1);
      rd(4'd8, s);
      chk("R11 status cleared at start", 64'(s[0]), 64'h0);
      lat = 0;
      while (!sck && lat < 1000) begin
         @(negedge clk);
         lat++;
      end
      wait_done();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int lat;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(4'd8, d);
      chk("R1 cs_n", 64'(cs_n), 64'h1);
      chk("R1 sck", 64'(sck), 64'h0);
      chk("R1 io_oe", 64'(io_oe), 64'h0);
      chk("R1 status", 64'(d), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2/R3/R10: single opcode, one lane, setup 0
      wr(4'd9, 32'h0000_0000);
      wr(4'd1, 32'h0000_009F);
      wr(4'd4, 32'h0000_0001);
      wr(4'd5, 32'h0000_0000);
      push_phase({8'h9F, 56'b0}, 8, 1, 0);
      launch(32'h0, lat);
      chk("R10 latency setup=0", 64'(lat), 64'd4);
      chk("R2 groups consumed", 64'(q.size()), 64'd0);
      chk("R2 sck rises", 64'(rises), 64'd8);
      rd(4'd8, d);
      chk("R11 status after end", 64'(d), 64'h1);
      chk("R12 sck idle", 64'(sck), 64'h0);
      chk("R12 cs_n idle", 64'(cs_n), 64'h1);

      // R10: setup 5
      wr(4'd9, 32'h0000_0325);
      push_phase({8'h9F, 56'b0}, 8, 1, 0);
      launch(32'h0, lat);
      chk("R10 latency setup=5", 64'(lat), 64'd9);

      // R4/R5/R12: opcode, 3-byte address, 2-byte write, one lane
      wr(4'd1, 32'h0000_0002);
      wr(4'd2, 32'h0012_3456);
      wr(4'd6, 32'hA5C3_0000);
      wr(4'd4, 32'h0000_C071);
      push_phase({8'h02, 56'b0}, 8, 1, 0);
      push_phase({24'h123456, 40'b0}, 24, 1, 0);
      push_phase({16'hA5C3, 48'b0}, 16, 1, 0);
      launch(32'h4, lat);
      chk("R4 R5 groups consumed", 64'(q.size()), 64'd0);
      chk("R4 R5 sck rises", 64'(rises), 64'd48);

      // R3/R4/R6/R7: quad address, option, dummy 6, quad read
      io_in = 4'b0101;
      wr(4'd1, 32'h0000_00EB);
      wr(4'd2, 32'h89AB_CDEF);
      wr(4'd3, 32'hA000_0000);
      wr(4'd4, (32'd5 << 17) | (32'd1 << 16) | 32'h0000_F8F1);
      wr(4'd5, 32'h0000_02A0);
      push_phase({8'hEB, 56'b0}, 8, 1, 0);
      push_phase({32'h89ABCDEF, 32'b0}, 32, 4, 0);
      push_phase({8'hA0, 56'b0}, 8, 4, 0);
      launch(32'h2, lat);
      chk("R3 R4 groups consumed", 64'(q.size()), 64'd0);
      chk("R6 dummy plus phases rises", 64'(rises), 64'd32);
      rd(4'd6, d);
      chk("R7 quad read word 6", 64'(d), 64'h5555_5555);
      rd(4'd7, d);
      chk("R7 quad read word 7", 64'(d), 64'h0);

      // R7: dual read one byte
      io_in = 4'b0010;
      wr(4'd4, 32'h0000_8001);
      wr(4'd5, 32'h0000_0100);
      push_phase({8'hEB, 56'b0}, 8, 1, 0);
      launch(32'h2, lat);
      chk("R7 dual rises", 64'(rises), 64'd12);
      rd(4'd6, d);
      chk("R7 dual read", 64'(d), 64'h0000_00AA);

      // R2/R7: two opcodes then single-lane read from io_in[1]
      wr(4'd1, 32'h0000_EE11);
      wr(4'd4, 32'h0000_8003);
      wr(4'd5, 32'h0000_0000);
      push_phase({8'h11, 56'b0}, 8, 1, 0);
      push_phase({8'hEE, 56'b0}, 8, 1, 0);
      launch(32'h2, lat);
      chk("R2 opcode order consumed", 64'(q.size()), 64'd0);
      chk("R2 rises", 64'(rises), 64'd24);
      rd(4'd6, d);
      chk("R7 single lane read", 64'(d), 64'h0000_00FF);

      // R5: 8-byte dual write, high word first
      wr(4'd6, 32'h89AB_CDEF);
      wr(4'd7, 32'h0123_4567);
      wr(4'd4, 32'h0040_F000);
      wr(4'd5, 32'h0000_0100);
      push_phase(64'h0123_4567_89AB_CDEF, 64, 2, 0);
      launch(32'h4, lat);
      chk("R5 eight byte consumed", 64'(q.size()), 64'd0);
      chk("R5 eight byte rises", 64'(rises), 64'd32);

      // R8: quad DDR address
      wr(4'd1, 32'h0000_0038);
      wr(4'd2, 32'h0F1E_2D3C);
      wr(4'd4, 32'h0000_00F1);
      wr(4'd5, 32'h0004_0020);
      push_phase({8'h38, 56'b0}, 8, 1, 0);
      push_phase({32'h0F1E2D3C, 32'b0}, 32, 4, 1);
      launch(32'h0, lat);
      chk("R8 ddr consumed", 64'(q.size()), 64'd0);
      chk("R8 ddr rises", 64'(rises), 64'd12);

      // R9: held frame over two transactions
      wr(4'd5, 32'h0000_0000);
      wr(4'd1, 32'h0000_0006);
      wr(4'd4, 32'h0000_0001);
      io_in = 4'b0001;
      cs_rises = 0;
      push_phase({8'h06, 56'b0}, 8, 1, 0);
      launch(32'h8, lat);
      rd(4'd8, d);
      chk("R9 status with keep", 64'(d), 64'h3);
      chk("R9 cs_n held", 64'(cs_n), 64'h0);
      wr(4'd1, 32'h0000_0005);
      wr(4'd4, 32'h0000_8001);
      push_phase({8'h05, 56'b0}, 8, 1, 0);
      launch(32'h2, lat);
      chk("R9 no setup when held", 64'(lat), 64'd3);
      chk("R9 rises", 64'(rises), 64'd16);
      chk("R9 single cs release", 64'(cs_rises), 64'd1);
      chk("R9 cs_n released", 64'(cs_n), 64'h1);
      rd(4'd6, d);
      chk("R7 io_in[1] low reads zero", 64'(d), 64'h0);
      chk("R12 io_oe idle", 64'(io_oe), 64'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule